// File: doc/BRIEF.md
# Inter-Core Interrupt Controller

This block lets any core of a multicore cluster interrupt any other core and hand it a 16-bit message. Each core owns an 8-byte register window made of a control word and a status word. A core starts a remote interrupt by writing its own control word with the raise flag set, a target core index and a message value. The target's pending flag then sets, and it keeps that core's interrupt line high. The target sees who sent the message, and what it was, in its own status word. It clears the pending flag by writing its own control word with the clear flag set.

The register port is a plain 32-bit word bus. It accepts one access in every cycle and never stalls, so it has no back-pressure. Read data is registered and appears one cycle after the read request. Writes take effect at the clock edge that samples them. Interrupt outputs come straight from flops, one line per core. Words are whole 32-bit values with bit 31 as the most significant bit. Byte-lane ordering on the host side belongs to the bus fabric.

Top module: `xcore_irq_ctrl`

## Requirements
- R1: After reset every interrupt output is low, and every status and control word reads 0.
- R2: Core n's window starts at byte address n*8. The control word is at +0 and the status word is at +4. Address bits 1:0 are ignored. Read data appears on `bus_rdata` one cycle after a read request and holds until the next read.
- R3: A write to core s's control word with bit 30 set and bits 29:16 equal to a target d below NUM_CORES sets d's pending flag. `irq_out[d]` goes high at the clock edge that samples the write.
- R4: Core d's status word reads bit 30 = pending, bits 29:16 = index of the sender, bits 15:0 = message from the sender's bits 15:0, and bit 31 = 0.
- R5: A write to core n's own control word with bit 31 set clears n's pending flag. `irq_out[n]` drops at that clock edge. The status sender and message fields keep their last values.
- R6: If one write both clears and raises for the same core, pending stays set and the status fields take the new sender and message.
- R7: A raise whose target index is NUM_CORES or higher changes no interrupt output and no status word.
- R8: Reads of windows at or above NUM_CORES return 0. Writes there have no effect.
- R9: Writes to a status word have no effect.
- R10: A pending flag stays set until it is cleared. A further raise to a core that is already pending overwrites its sender and message fields.
- R11: A control word reads back bits 29:16 and 15:0 of its last write, with bits 31:30 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (ADDR_W = index bits + 3) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CORES | Interrupt line per core |

## Verification
A wrong pending flag shows on `irq_out` at the very edge that samples the faulty write, so the interrupt checks sample half a cycle after each write. Wrong sender or message capture only shows in a status read, one cycle after the read request. For that reason each raise, clear or ignored write is followed by a status read of the affected core, and by reads of cores that must stay untouched. Decode faults, such as a wrong window, the status word accepting writes, or an out-of-range target being honoured, show up as an interrupt line changing, or a status word changing, where none should.

// File: rtl/xcore_irq_pkg.sv
package xcore_irq_pkg;
  localparam int unsigned PEER_W = 14;
  localparam int unsigned MSG_W  = 16;
  localparam int unsigned WORD_W = 32;

  // control word as written by a core into its own window
  typedef struct packed {
    logic              clr;
    logic              raise;
    logic [PEER_W-1:0] peer;
    logic [MSG_W-1:0]  msg;
  } ctrl_word_t;

  // status word as seen by the receiving core
  typedef struct packed {
    logic              rsvd;
    logic              pend;
    logic [PEER_W-1:0] peer;
    logic [MSG_W-1:0]  msg;
  } stat_word_t;
endpackage

// File: rtl/xcore_bus_decode.sv
module xcore_bus_decode
  import xcore_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned IDX_W     = 2,
  localparam int unsigned ADDR_W   = IDX_W + 3
) (
  input  logic                 sel,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output ctrl_word_t           word,
  output logic [IDX_W-1:0]     win,
  output logic                 win_ok,
  output logic                 is_stat,
  output logic [NUM_CORES-1:0] ctrl_wr_oh,
  output logic [NUM_CORES-1:0] raise_oh,
  output logic                 rd_en
);
  logic any_ctrl_wr;

  assign word    = ctrl_word_t'(wdata);
  assign win     = addr[ADDR_W-1:3];
  assign is_stat = addr[2];
  assign win_ok  = 32'(win) < 32'(NUM_CORES);
  assign rd_en   = sel & ~wr;

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_dec
    assign ctrl_wr_oh[n] = sel & wr & win_ok & ~is_stat & (win == IDX_W'(n));
    assign raise_oh[n]   = any_ctrl_wr & word.raise & (word.peer == PEER_W'(n));
  end

  assign any_ctrl_wr = |ctrl_wr_oh;
endmodule

// File: rtl/xcore_irq_slot.sv
module xcore_irq_slot
  import xcore_irq_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] sender_i,
  input  logic [MSG_W-1:0] msg_i,
  output stat_word_t       stat_o
);
  logic              pend_q;
  logic [PEER_W-1:0] peer_q;
  logic [MSG_W-1:0]  msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      peer_q <= '0;
      msg_q  <= '0;
    end else if (set_i) begin
      // a raise wins over a clear arriving in the same cycle
      pend_q <= 1'b1;
      peer_q <= PEER_W'(sender_i);
      msg_q  <= msg_i;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end
  end

  assign stat_o = '{rsvd: 1'b0, pend: pend_q, peer: peer_q, msg: msg_q};
endmodule

// File: rtl/xcore_read_mux.sv
module xcore_read_mux
  import xcore_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic                              rd_ok,
  input  logic                              rd_stat,
  input  logic [IDX_W-1:0]                  rd_win,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  ctrl_view,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  stat_view,
  output logic [WORD_W-1:0]                 rdata
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    pick = '0;
    if (rd_ok) pick = rd_stat ? stat_view[rd_win] : ctrl_view[rd_win];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= pick;
  end
endmodule

// File: rtl/xcore_irq_ctrl.sv
module xcore_irq_ctrl
  import xcore_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned ADDR_W   = IDX_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq_out
);
  ctrl_word_t                        word;
  logic [IDX_W-1:0]                  win;
  logic                              win_ok, is_stat, rd_en;
  logic [NUM_CORES-1:0]              ctrl_wr_oh, raise_oh;
  logic [NUM_CORES-1:0][WORD_W-1:0]  ctrl_view, stat_view;

  xcore_bus_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .word(word), .win(win), .win_ok(win_ok), .is_stat(is_stat),
    .ctrl_wr_oh(ctrl_wr_oh), .raise_oh(raise_oh), .rd_en(rd_en)
  );

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    stat_word_t              stat;
    logic [PEER_W+MSG_W-1:0] shadow_q;

    xcore_irq_slot #(.IDX_W(IDX_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .set_i(raise_oh[n]), .clr_i(ctrl_wr_oh[n] & word.clr),
      .sender_i(win), .msg_i(word.msg), .stat_o(stat)
    );

    always_ff @(posedge clk) begin
      if (!rst_n)             shadow_q <= '0;
      else if (ctrl_wr_oh[n]) shadow_q <= {word.peer, word.msg};
    end

    assign stat_view[n] = stat;
    assign ctrl_view[n] = {2'b00, shadow_q};
    assign irq_out[n]   = stat.pend;
  end

  xcore_read_mux #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ok(win_ok),
    .rd_stat(is_stat), .rd_win(win),
    .ctrl_view(ctrl_view), .stat_view(stat_view), .rdata(bus_rdata)
  );
endmodule

// File: rtl/xcore_irq_sva.sv
module xcore_irq_sva #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CORES-1:0] irq_out
);
  logic [ADDR_W-4:0] win;
  logic              wr_ctrl, mapped;

  assign win     = bus_addr[ADDR_W-1:3];
  assign mapped  = 32'(win) < 32'(NUM_CORES);
  assign wr_ctrl = bus_sel && bus_wr && !bus_addr[2] && mapped;

  // R8: unmapped windows read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped) |=> (bus_rdata == 32'h0));

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_chk
    // R3: a valid raise sets the target line
    a_r3_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[30] && bus_wdata[29:16] == 14'(n)) |=> irq_out[n]);

    // R5: a clear from the owner drops its line unless it also raises itself
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && win == (ADDR_W-3)'(n) && bus_wdata[31] &&
       !(bus_wdata[30] && bus_wdata[29:16] == 14'(n))) |=> !irq_out[n]);

    // R10: with no write, lines hold
    a_r10_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(irq_out[n]));

    // R7: a line only rises after a raise naming it
    a_r7_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[n]) |->
        $past(wr_ctrl && bus_wdata[30] && bus_wdata[29:16] == 14'(n)));
  end
endmodule

bind xcore_irq_ctrl xcore_irq_sva #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out)
);

// File: tb/tb_xcore_irq_ctrl.sv
`timescale 1ns/1ps
module tb_xcore_irq_ctrl;
  localparam int unsigned NC = 3;
  localparam int unsigned AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  xcore_irq_ctrl #(.NUM_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] raise_word(input int dst, input logic [15:0] msg);
    return 32'h4000_0000 | (32'(dst) << 16) | 32'(msg);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", 32'(irq_out), 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(AW'(c*8 + 4), v); check("R1 status after reset", v, 32'h0);
      rd(AW'(c*8), v);     check("R1 ctrl after reset", v, 32'h0);
    end
  endtask

  task automatic t_raise_basic();
    logic [31:0] v;
    wr(AW'(0), raise_word(2, 16'hBEEF));
    check("R3 raise core0->core2 irq", 32'(irq_out), 32'h4);
    rd(AW'(20), v); check("R4 status of core2", v, 32'h4000_BEEF);
    rd(AW'(23), v); check("R2 low address bits ignored", v, 32'h4000_BEEF);
    rd(AW'(0), v);  check("R11 ctrl readback core0", v, 32'h0002_BEEF);
  endtask

  task automatic t_overwrite();
    logic [31:0] v;
    wr(AW'(8), raise_word(2, 16'h1234));
    check("R10 line held on repeat raise", 32'(irq_out), 32'h4);
    rd(AW'(20), v); check("R10 latest sender and message", v, 32'h4001_1234);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(AW'(16), 32'h8000_0000);
    check("R5 clear drops core2 line", 32'(irq_out), 32'h0);
    rd(AW'(20), v); check("R5 fields kept after clear", v, 32'h0001_1234);
  endtask

  task automatic t_clear_and_raise();
    logic [31:0] v;
    wr(AW'(0), raise_word(1, 16'h0055));
    check("R3 raise core0->core1", 32'(irq_out), 32'h2);
    wr(AW'(8), 32'h8000_0000 | raise_word(1, 16'h0066));
    check("R6 pending kept on clear+raise", 32'(irq_out), 32'h2);
    rd(AW'(12), v); check("R6 new fields on clear+raise", v, 32'h4001_0066);
  endtask

  task automatic t_bad_target();
    logic [31:0] v;
    wr(AW'(0), raise_word(3, 16'hAAAA));
    check("R7 target 3 ignored irq", 32'(irq_out), 32'h2);
    wr(AW'(16), raise_word(16'h3FFF, 16'hBBBB));
    check("R7 target 3FFF ignored irq", 32'(irq_out), 32'h2);
    rd(AW'(4), v);  check("R7 core0 status untouched", v, 32'h0);
    rd(AW'(20), v); check("R7 core2 status untouched", v, 32'h0001_1234);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(AW'(24), v); check("R8 unmapped ctrl reads 0", v, 32'h0);
    rd(AW'(28), v); check("R8 unmapped status reads 0", v, 32'h0);
    wr(AW'(24), raise_word(0, 16'h7777));
    check("R8 unmapped write no irq", 32'(irq_out), 32'h2);
    rd(AW'(4), v);  check("R8 core0 status after unmapped write", v, 32'h0);
  endtask

  task automatic t_status_write();
    logic [31:0] v;
    wr(AW'(4), 32'hFFFF_FFFF);
    check("R9 status write no irq", 32'(irq_out), 32'h2);
    rd(AW'(4), v);  check("R9 status write no effect", v, 32'h0);
    wr(AW'(12), 32'h8000_0000);
    check("R9 status write does not clear", 32'(irq_out), 32'h2);
    wr(AW'(8), 32'h8000_0000);
    check("R5 core1 clear", 32'(irq_out), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raise_basic();
    t_overwrite();
    t_clear();
    t_clear_and_raise();
    t_bad_target();
    t_unmapped();
    t_status_write();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule